// File: doc/BRIEF.md
# CAN Identifier Acceptance Mask Filter

This block decides whether a received CAN frame identifier is accepted by one message object. It compares the incoming identifier against the identifier stored in the object under a programmable mask. The frame's IDE flag picks which global mask applies: an 11-bit mask for standard frames or a 29-bit mask for extended frames. A mask bit of 1 requires the two identifiers to agree at that position. A mask bit of 0 leaves that position uncompared.

One object can be flagged as the final object of the set. For that object only, a further 29-bit mask covering the whole arbitration field is ANDed with the selected global mask. The block evaluates one identifier each time `valid_in` is pulsed. It returns a registered verdict one clock later, marked by `valid_out`. Buffer storage, arbitration among objects and frame reception belong to other blocks.

Top module: `can_id_accept_filter`

## Requirements
- R1: While reset is active, and in the cycles after it until the first strobe, `valid_out` and `accept` are 0.
- R2: `valid_out` is 1 exactly in the cycle after a cycle with `valid_in` = 1. `accept` is never 1 unless `valid_out` is 1.
- R3: A frame whose `rx_ext` differs from `obj_ext` is never accepted, even if the identifiers are equal.
- R4: For a standard frame (`rx_ext` = 0), bit i of `gmask_std` (i = 0..10) governs the comparison of identifier bit 18+i. Identifier bit 28 is the first bit on the bus.
- R5: For a standard frame, identifier bits 17..0 are never compared.
- R6: For an extended frame (`rx_ext` = 1), bit i of `gmask_ext` governs the comparison of identifier bit i (i = 0..28).
- R7: A mask bit of 1 requires equality at its position. A mask bit of 0 means that position is not compared.
- R8: When `is_last` = 1, the effective mask is the selected global mask ANDed bitwise with `last_mask`, which is aligned to identifier bits 28..0.
- R9: When `is_last` = 0, `last_mask` has no effect, as if it were all ones.
- R10: A strobe with equal IDE flags and equal identifiers is always accepted, whatever the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| valid_in | input | 1 | Strobe: evaluate the identifier presented this cycle |
| rx_id | input | 29 | Received identifier, bits 28..0; a standard identifier sits in bits 28..18 |
| rx_ext | input | 1 | Received IDE flag, 1 = extended frame |
| obj_id | input | 29 | Stored object identifier, same alignment as `rx_id` |
| obj_ext | input | 1 | Stored object IDE flag |
| gmask_std | input | 11 | Global standard mask, bit i covers identifier bit 18+i |
| gmask_ext | input | 29 | Global extended mask, bit i covers identifier bit i |
| last_mask | input | 29 | Extra mask of the final object, bit i covers identifier bit i |
| is_last | input | 1 | 1 = this object is the final object and `last_mask` applies |
| valid_out | output | 1 | Verdict valid, one cycle after `valid_in` |
| accept | output | 1 | 1 = frame accepted by this object |

## Verification
A fault in mask selection or alignment shows up as a wrong `accept` in the cycle right after the strobe. It appears only when the identifiers differ at a position the faulty mask handles. The bench therefore flips single bits at the edges of each field: bit 18 and bit 28 for standard frames, low bits for extended frames. A stuck output register shows as a `valid_out` or `accept` that persists into idle cycles. The bench checks for that one cycle after each strobe.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int unsigned ID_W  = 29;
  localparam int unsigned STD_W = 11;
  localparam int unsigned STD_LSB = ID_W - STD_W;

  typedef logic [ID_W-1:0]  id_t;
  typedef logic [STD_W-1:0] std_mask_t;

  typedef struct packed {
    logic valid;
    logic accept;
  } verdict_t;
endpackage

// File: rtl/can_acc_rst_sync.sv
module can_acc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/can_acc_mask_sel.sv
module can_acc_mask_sel
  import can_acc_pkg::*;
#(
  parameter int unsigned IW = ID_W,
  parameter int unsigned SW = STD_W
) (
  input  logic          frame_ext,
  input  logic [SW-1:0] gmask_std,
  input  logic [IW-1:0] gmask_ext,
  input  logic [IW-1:0] last_mask,
  input  logic          is_last,
  output logic [IW-1:0] eff_mask
);
  localparam int unsigned LOW_W = IW - SW;

  logic [IW-1:0] std_wide;
  logic [IW-1:0] glob_mask;
  logic [IW-1:0] obj_mask;

  // Standard mask sits on the top bits; the low part is never compared.
  assign std_wide  = {gmask_std, {LOW_W{1'b0}}};
  assign glob_mask = frame_ext ? gmask_ext : std_wide;
  assign obj_mask  = is_last ? last_mask : {IW{1'b1}};

  genvar b;
  generate
    for (b = 0; b < IW; b++) begin : g_and
      assign eff_mask[b] = glob_mask[b] & obj_mask[b];
    end
  endgenerate
endmodule

// File: rtl/can_acc_compare.sv
module can_acc_compare #(
  parameter int unsigned IW = 29
) (
  input  logic [IW-1:0] rx_id,
  input  logic [IW-1:0] obj_id,
  input  logic          rx_ext,
  input  logic          obj_ext,
  input  logic [IW-1:0] eff_mask,
  output logic          match
);
  logic [IW-1:0] diff_bits;
  logic          ide_same;

  assign diff_bits = (rx_id ^ obj_id) & eff_mask;
  assign ide_same  = ~(rx_ext ^ obj_ext);
  assign match     = ide_same & ~(|diff_bits);
endmodule

// File: rtl/can_id_accept_filter.sv
module can_id_accept_filter
  import can_acc_pkg::*;
#(
  parameter int unsigned IW = ID_W,
  parameter int unsigned SW = STD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [IW-1:0] rx_id,
  input  logic          rx_ext,
  input  logic [IW-1:0] obj_id,
  input  logic          obj_ext,
  input  logic [SW-1:0] gmask_std,
  input  logic [IW-1:0] gmask_ext,
  input  logic [IW-1:0] last_mask,
  input  logic          is_last,
  output logic          valid_out,
  output logic          accept
);
  logic          rst_ok_n;
  logic [IW-1:0] eff_mask;
  logic          match;
  verdict_t      verdict_q;
  verdict_t      verdict_d;

  can_acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  can_acc_mask_sel #(.IW(IW), .SW(SW)) u_mask_sel (
    .frame_ext (rx_ext),
    .gmask_std (gmask_std),
    .gmask_ext (gmask_ext),
    .last_mask (last_mask),
    .is_last   (is_last),
    .eff_mask  (eff_mask)
  );

  can_acc_compare #(.IW(IW)) u_cmp (
    .rx_id    (rx_id),
    .obj_id   (obj_id),
    .rx_ext   (rx_ext),
    .obj_ext  (obj_ext),
    .eff_mask (eff_mask),
    .match    (match)
  );

  always_comb begin
    verdict_d.valid  = valid_in;
    verdict_d.accept = valid_in & match;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) verdict_q <= '0;
    else           verdict_q <= verdict_d;
  end

  assign valid_out = verdict_q.valid;
  assign accept    = verdict_q.accept;
endmodule

module can_id_accept_filter_chk #(
  parameter int unsigned IW = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_in,
  input logic [IW-1:0] rx_id,
  input logic          rx_ext,
  input logic [IW-1:0] obj_id,
  input logic          obj_ext,
  input logic          valid_out,
  input logic          accept
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  p_accept_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> valid_out);
  p_ide_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (rx_ext != obj_ext)) |=> !accept);
  p_exact_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (rx_ext == obj_ext) && (rx_id == obj_id)) |=> accept);
endmodule

bind can_id_accept_filter can_id_accept_filter_chk #(.IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ok_n),
  .valid_in  (valid_in),
  .rx_id     (rx_id),
  .rx_ext    (rx_ext),
  .obj_id    (obj_id),
  .obj_ext   (obj_ext),
  .valid_out (valid_out),
  .accept    (accept)
);

// File: tb/can_id_accept_filter_tb.sv
module can_id_accept_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        valid_in;
  logic [28:0] rx_id;
  logic        rx_ext;
  logic [28:0] obj_id;
  logic        obj_ext;
  logic [10:0] gmask_std;
  logic [28:0] gmask_ext;
  logic [28:0] last_mask;
  logic        is_last;
  logic        valid_out;
  logic        accept;

  int n_checks;
  int n_fail;

  can_id_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .rx_id(rx_id), .rx_ext(rx_ext), .obj_id(obj_id), .obj_ext(obj_ext),
    .gmask_std(gmask_std), .gmask_ext(gmask_ext), .last_mask(last_mask),
    .is_last(is_last), .valid_out(valid_out), .accept(accept)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One strobe; checks verdict one cycle later and idle the cycle after.
  task automatic strobe(input string req, input logic [28:0] rid, input logic rext,
                        input logic [28:0] oid, input logic oext, input logic exp_acc);
    @(negedge clk);
    rx_id = rid; rx_ext = rext; obj_id = oid; obj_ext = oext; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    check({req, " valid_out"}, valid_out, 1'b1);
    check({req, " accept"}, accept, exp_acc);
    @(negedge clk);
    check({req, " idle valid_out (R2)"}, valid_out, 1'b0);
    check({req, " idle accept (R2)"}, accept, 1'b0);
  endtask

  task automatic set_masks(input logic [10:0] ms, input logic [28:0] me,
                           input logic [28:0] ml, input logic lst);
    gmask_std = ms; gmask_ext = me; last_mask = ml; is_last = lst;
  endtask

  task automatic t_reset;
    check("R1 reset valid_out", valid_out, 1'b0);
    check("R1 reset accept", accept, 1'b0);
  endtask

  task automatic t_exact;
    set_masks('1, '1, '1, 1'b0);
    strobe("R10 std exact", 29'h1ABC_0000, 1'b0, 29'h1ABC_0000, 1'b0, 1'b1);
    strobe("R10 ext exact", 29'h0123_4567, 1'b1, 29'h0123_4567, 1'b1, 1'b1);
  endtask

  task automatic t_standard;
    set_masks('1, '1, '1, 1'b0);
    strobe("R4 std bit18 differs", 29'h0004_0000, 1'b0, 29'h0, 1'b0, 1'b0);
    strobe("R4 std bit28 differs", 29'h1000_0000, 1'b0, 29'h0, 1'b0, 1'b0);
    set_masks(11'h7FE, '1, '1, 1'b0);
    strobe("R7 std bit18 dont care", 29'h0004_0000, 1'b0, 29'h0, 1'b0, 1'b1);
    set_masks(11'h3FF, '1, '1, 1'b0);
    strobe("R7 std bit28 dont care", 29'h1000_0000, 1'b0, 29'h0, 1'b0, 1'b1);
    set_masks('1, '1, '1, 1'b0);
    strobe("R5 std low bits ignored", 29'h0003_FFFF, 1'b0, 29'h0, 1'b0, 1'b1);
  endtask

  task automatic t_extended;
    set_masks('1, '1, '1, 1'b0);
    strobe("R6 ext bit0 differs", 29'h0000_0001, 1'b1, 29'h0, 1'b1, 1'b0);
    set_masks('1, 29'h1FFF_FFFE, '1, 1'b0);
    strobe("R7 ext bit0 dont care", 29'h0000_0001, 1'b1, 29'h0, 1'b1, 1'b1);
    strobe("R6 ext bit1 still compared", 29'h0000_0002, 1'b1, 29'h0, 1'b1, 1'b0);
    set_masks('0, '1, '1, 1'b0);
    strobe("R6 ext ignores std mask", 29'h0000_0010, 1'b1, 29'h0, 1'b1, 1'b0);
  endtask

  task automatic t_ide;
    set_masks('0, '0, '1, 1'b0);
    strobe("R3 std rx vs ext obj", 29'h55, 1'b0, 29'h55, 1'b1, 1'b0);
    strobe("R3 ext rx vs std obj", 29'h55, 1'b1, 29'h55, 1'b0, 1'b0);
  endtask

  task automatic t_last;
    set_masks('1, '1, 29'h1FEF_FFFF, 1'b1);
    strobe("R8 last mask clears bit20", 29'h0010_0000, 1'b1, 29'h0, 1'b1, 1'b1);
    set_masks(11'h7FB, '1, '1, 1'b1);
    strobe("R8 global clears bit20", 29'h0010_0000, 1'b0, 29'h0, 1'b0, 1'b1);
    set_masks('1, '1, '1, 1'b1);
    strobe("R8 both set bit3 ext", 29'h0000_0008, 1'b1, 29'h0, 1'b1, 1'b0);
    set_masks('1, '1, 29'h0, 1'b0);
    strobe("R9 non-last ignores last_mask", 29'h0000_0008, 1'b1, 29'h0, 1'b1, 1'b0);
  endtask

  task automatic t_no_strobe;
    set_masks('1, '1, '1, 1'b0);
    @(negedge clk);
    rx_id = 29'h7; obj_id = 29'h7; rx_ext = 1'b1; obj_ext = 1'b1; valid_in = 1'b0;
    @(negedge clk);
    check("R2 no strobe valid_out", valid_out, 1'b0);
    check("R2 no strobe accept", accept, 1'b0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; valid_in = 1'b0;
    rx_id = '0; rx_ext = 1'b0; obj_id = '0; obj_ext = 1'b0;
    set_masks('1, '1, '1, 1'b0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_exact();
    t_standard();
    t_extended();
    t_ide();
    t_last();
    t_no_strobe();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule